// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner with Lock Detection

This block is the receive side of a serial link that carries 12-bit frames. Each frame is one start bit, ten data bits and one stop bit. The block does not recover the clock. Bits arrive one at a time on `bit_in`, and each bit counts only when `bit_en` is high on a `clk` edge.

While it is unlocked, the block hunts for frame alignment. It compares the last twelve received bits against the sync pattern at every bit time. The sync pattern is six ones followed by six zeros. Once enough consecutive sync frames have arrived on the same alignment, the block declares lock.

While it is locked, the block checks the framing bits of every frame. A frame that passes is presented as a 10-bit word with a one-cycle strobe. A single bad frame does not drop lock. A run of bad frames does, and the block then returns to hunting.

An output enable and an active-low powerdown input control what the outputs show. They do not drive anything to tri-state. When the outputs are disabled or the block is unlocked, the outputs read as invalid: the lock flag is high, there is no strobe, and the word is zero.

Top module: `frame_lock_rx`

## Requirements
- R1: After reset, `lock_n` is 1, `word_vld` is 0 and `word_o` is 0.
- R2: Bits arrive in order, and the first bit of a frame is its start bit. The sync frame is six 1s followed by six 0s, that is 12'hFC0 with bit 11 received first.
- R3: While hunting, lock is declared after SYNC_MATCHES (default 4) consecutive sync frames spaced exactly 12 accepted bits apart. `lock_n` falls in the cycle after the edge that accepts the last bit of that final sync frame. Fewer sync frames leave `lock_n` high.
- R4: A locked frame is good when its first bit is 1 and its last bit is 0. For a good frame, `word_vld` pulses for one cycle after the edge that accepts the last bit. At that time `word_o` holds the ten data bits, with the first data bit received in `word_o[9]`. A sync frame received while locked is delivered as 10'h3E0.
- R5: A locked frame with a bad start or stop bit gives no `word_vld`. Fewer than LOSS_FRAMES (default 4) consecutive bad frames keep lock. A good frame resets the run of bad frames.
- R6: LOSS_FRAMES consecutive bad frames raise `lock_n` after the edge that accepts the last bit of the final bad frame. The block then hunts again, and it delivers no words until it relocks.
- R7: While `out_en` is 0, `lock_n` is 1, `word_vld` is 0 and `word_o` is 0. Lock state is kept, and raising `out_en` again shows lock without any new sync frames.
- R8: While `pwr_n` is 0, all state is cleared and `lock_n` is 1. After `pwr_n` returns to 1, lock needs a fresh run of sync frames.
- R9: `bit_in` is ignored on cycles where `bit_en` is 0.
- R10: A non-sync frame in the middle of a hunting run of sync frames restarts the count of consecutive matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` on this edge |
| bit_in | input | 1 | Recovered serial bit |
| out_en | input | 1 | Output enable; when low, the outputs read as invalid |
| pwr_n | input | 1 | Powerdown, active low; clears state |
| word_o | output | FRAME_BITS-2 | Received data word; zero when invalid |
| word_vld | output | 1 | One-cycle strobe for a good locked frame |
| lock_n | output | 1 | Low when locked and enabled |

## Verification
The hardest condition to reach from the ports is the boundary of lock loss. The block must hold lock through exactly LOSS_FRAMES-1 bad frames followed by a good one, and lose lock on the LOSS_FRAMES-th consecutive bad frame. The bench reaches this boundary with directed runs of three and four bad frames. It then continues with random traffic in which bad frames occur often enough to form runs. A bench-side model tracks the run of bad frames and the sync-match count, and after every unlock the bench drives the block through hunting and relocking. Random idle gaps with random `bit_in` values sit between accepted bits throughout, so alignment must survive idle cycles.

// File: rtl/frame_lock_rx.sv
module frame_lock_rx #(
  parameter int FRAME_BITS   = 12,
  parameter int SYNC_MATCHES = 4,
  parameter int LOSS_FRAMES  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  bit_in,
  input  logic                  out_en,
  input  logic                  pwr_n,
  output logic [FRAME_BITS-3:0] word_o,
  output logic                  word_vld,
  output logic                  lock_n
);
  localparam int DW = FRAME_BITS - 2;
  localparam int HALF = FRAME_BITS / 2;
  localparam int PW = $clog2(FRAME_BITS);
  localparam int MW = $clog2(SYNC_MATCHES + 1);
  localparam int LW = $clog2(LOSS_FRAMES + 1);
  localparam logic [FRAME_BITS-1:0] SYNC_PAT = {{HALF{1'b1}}, {(FRAME_BITS-HALF){1'b0}}};

  logic [FRAME_BITS-1:0] shreg;
  logic [PW-1:0]         pos;
  logic [MW-1:0]         mcnt, mnext;
  logic [LW-1:0]         bad;
  logic [DW-1:0]         word_q;
  logic                  vld_q, locked;

  wire [FRAME_BITS-1:0] nx = {shreg[FRAME_BITS-2:0], bit_in};
  wire frame_end = (pos == PW'(FRAME_BITS - 1));
  wire is_sync   = (nx == SYNC_PAT);
  wire frame_ok  = nx[FRAME_BITS-1] & ~nx[0];
  wire en_ok     = out_en & pwr_n;

  always_comb begin
    if (mcnt != '0 && frame_end) mnext = mcnt + MW'(1);
    else                         mnext = MW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      pos    <= '0;
      mcnt   <= '0;
      bad    <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      locked <= 1'b0;
    end else if (!pwr_n) begin
      shreg  <= '0;
      pos    <= '0;
      mcnt   <= '0;
      bad    <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      locked <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (bit_en) begin
        shreg <= nx;
        pos   <= frame_end ? '0 : pos + PW'(1);
        if (!locked) begin
          if (is_sync) begin
            pos <= '0;
            if (mnext == MW'(SYNC_MATCHES)) begin
              locked <= 1'b1;
              mcnt   <= '0;
              bad    <= '0;
            end else begin
              mcnt <= mnext;
            end
          end else if (frame_end) begin
            mcnt <= '0;
          end
        end else if (frame_end) begin
          if (frame_ok) begin
            word_q <= nx[FRAME_BITS-2:1];
            vld_q  <= 1'b1;
            bad    <= '0;
          end else if (bad == LW'(LOSS_FRAMES - 1)) begin
            locked <= 1'b0;
            bad    <= '0;
            mcnt   <= '0;
          end else begin
            bad <= bad + LW'(1);
          end
        end
      end
    end
  end

  assign word_o   = (en_ok && locked) ? word_q : '0;
  assign word_vld = vld_q & en_ok;
  assign lock_n   = ~(locked & en_ok);
endmodule

// File: rtl/frame_lock_rx_chk.sv
module frame_lock_rx_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          out_en,
  input logic          pwr_n,
  input logic [DW-1:0] word_o,
  input logic          word_vld,
  input logic          lock_n
);
  AST_VLD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) word_vld |-> (!lock_n && out_en && pwr_n)); // R4
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) word_vld |=> !word_vld); // R4
  AST_VLD_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) word_vld |-> $past(bit_en)); // R9
  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) ($fell(lock_n) && out_en && pwr_n && $past(out_en && pwr_n)) |-> $past(bit_en)); // R3
  AST_LOSS_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) ($rose(lock_n) && out_en && pwr_n && $past(out_en && pwr_n)) |-> $past(bit_en)); // R6
  AST_PWRDN_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n) !pwr_n |=> lock_n); // R8
endmodule

bind frame_lock_rx frame_lock_rx_chk #(.DW(FRAME_BITS - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_en(out_en), .pwr_n(pwr_n),
  .word_o(word_o), .word_vld(word_vld), .lock_n(lock_n)
);

// File: tb/frame_lock_rx_test.sv
module frame_lock_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] SYNC = 12'hFC0;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, out_en = 1'b1, pwr_n = 1'b1;
  logic [9:0] word_o;
  logic word_vld, lock_n;
  int n_tests = 0, n_fail = 0;
  bit m_locked = 0;
  int m_match = 0, m_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_lock_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .out_en(out_en),
    .pwr_n(pwr_n), .word_o(word_o), .word_vld(word_vld), .lock_n(lock_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [9:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  // R9: idle cycles carry random bit_in that must be ignored
  task automatic send_bit(input logic b);
    repeat ($urandom_range(0, 2)) begin
      bit_in = 1'($urandom);
      @(negedge clk);
    end
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'($urandom);
  endtask

  task automatic send_frame(input logic [11:0] f);
    bit pre, exp_vld;
    pre = m_locked;
    exp_vld = 0;
    if (m_locked) begin
      if (f[11] && !f[0]) begin exp_vld = 1; m_bad = 0; end
      else begin
        m_bad++;
        if (m_bad == 4) begin m_locked = 0; m_bad = 0; m_match = 0; end
      end
    end else begin
      if (f == SYNC) begin
        m_match++;
        if (m_match == 4) begin m_locked = 1; m_match = 0; m_bad = 0; end
      end else m_match = 0;
    end
    for (int i = 11; i >= 0; i--) begin
      send_bit(f[i]);
      if (i > 0) begin
        chk(word_vld == 1'b0, "R4 no strobe mid-frame", word_vld, 0);
        chk(lock_n == !(pre && out_en), "R3/R6 lock mid-frame", lock_n, !(pre && out_en));
      end
    end
    chk(word_vld == (exp_vld && out_en), "R4/R5 strobe at frame end", word_vld, exp_vld && out_en);
    if (exp_vld && out_en) chk(word_o == f[10:1], "R2/R4 word", word_o, f[10:1]);
    chk(lock_n == !(m_locked && out_en), "R3/R6 lock at frame end", lock_n, !(m_locked && out_en));
  endtask

  function automatic logic [11:0] bad_frame(input logic [9:0] d, input int k);
    case (k % 3)
      0: return {1'b0, d, 1'b0};
      1: return {1'b1, d, 1'b1};
      default: return {1'b0, d, 1'b1};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(lock_n == 1'b1 && word_vld == 1'b0 && word_o == '0, "R1 reset state", {lock_n, word_vld, word_o}, 12'h800);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (7) send_bit(1'b0);

    repeat (3) send_frame(SYNC);
    chk(lock_n == 1'b1, "R3 three syncs not enough", lock_n, 1);
    send_frame(SYNC);
    chk(lock_n == 1'b0, "R3 lock after four syncs", lock_n, 0);

    send_frame(mk(10'h2C5));
    send_frame(SYNC);  // R4: delivered as 3E0
    chk(word_o == 10'h3E0, "R4 sync frame as data", word_o, 10'h3E0);

    for (int k = 0; k < 3; k++) send_frame(bad_frame(10'h155, k));
    chk(lock_n == 1'b0, "R5 lock held after three bad", lock_n, 0);
    send_frame(mk(10'h0F3));
    for (int k = 0; k < 3; k++) send_frame(bad_frame(10'h0AA, k));
    send_frame(mk(10'h301));
    chk(lock_n == 1'b0, "R5 good frame resets run", lock_n, 0);

    for (int k = 0; k < 4; k++) send_frame(bad_frame(10'h1C3, k));
    chk(lock_n == 1'b1, "R6 lock lost after four bad", lock_n, 1);
    send_frame(mk(10'h2AA));
    chk(word_vld == 1'b0, "R6 no words while hunting", word_vld, 0);

    send_frame(SYNC); send_frame(SYNC); send_frame(12'h555);
    repeat (3) send_frame(SYNC);
    chk(lock_n == 1'b1, "R10 count restarted", lock_n, 1);
    send_frame(SYNC);
    chk(lock_n == 1'b0, "R10 relock after restart", lock_n, 0);

    out_en = 1'b0;
    #1;
    chk(lock_n == 1'b1 && word_vld == 1'b0 && word_o == '0, "R7 disabled outputs", {lock_n, word_vld, word_o}, 12'h800);
    send_frame(mk(10'h111));
    out_en = 1'b1;
    #1;
    chk(lock_n == 1'b0, "R7 lock kept across disable", lock_n, 0);
    send_frame(mk(10'h222));

    repeat (20) begin bit_in = 1'($urandom); @(negedge clk); end
    send_frame(mk(10'h3A5));
    chk(word_o == 10'h3A5, "R9 idle bits ignored", word_o, 10'h3A5);

    pwr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock_n == 1'b1, "R8 powerdown unlocks", lock_n, 1);
    pwr_n = 1'b1;
    m_locked = 0; m_match = 0; m_bad = 0;
    @(negedge clk);
    send_frame(mk(10'h2AA));
    chk(lock_n == 1'b1 && word_vld == 1'b0, "R8 needs fresh sync", {lock_n, word_vld}, 2);
    repeat (4) send_frame(SYNC);

    for (int n = 0; n < 400; n++) begin
      int r;
      if (!m_locked) repeat (4) send_frame(SYNC);
      r = int'($urandom % 100);
      if (r < 6) for (int k = 0; k < 3; k++) send_frame(bad_frame(10'($urandom), k));
      else if (r < 22) send_frame(bad_frame(10'($urandom), int'($urandom % 3)));
      else send_frame(mk(10'($urandom)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule